// File: doc/BRIEF.md
# Context-Tagged Translation Buffer

This block is a fully associative cache of virtual-to-physical page translations for 8 KiB pages. Each slot keeps a virtual page number, a context number and a 64-bit attribute word. A lookup takes a 64-bit virtual address and a context. In the same cycle it returns hit or miss, the physical address and the access attributes. Software refills the buffer through an insert port. A single demap command drops every unlocked translation that belongs to one context.

Replacement is least-recently-used among unlocked slots. Empty slots are filled first. Both lookup hits and inserts count as uses. A translation marked global answers for every context. If every slot is valid and locked, an insert is refused and reported. The slot count is a parameter; the default is 16.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every slot is empty. A lookup then reports a miss, and `ins_err` is low.
- R2: Attribute word layout: bit 63 valid, bits 40..13 physical page number, bit 6 lock, bits 5..1 the permissions (cacheable-physical, cacheable-virtual, side-effect, privileged, writable, from high to low), bit 0 global. A lookup hits a valid slot whose stored page number equals VA bits 63..13 and whose context equals the lookup context. It then returns `lk_hit`=1, `lk_pa` = {page number, VA bits 12..0} and `lk_perm` = attribute bits 5..1. All of these appear in the same cycle.
- R3: A valid slot with the global bit set matches on page number alone, whatever the lookup context.
- R4: When a lookup finds no match, `lk_miss`=1, `lk_hit`=0, and `lk_pa` and `lk_perm` are zero. When `lk_valid` is low, both `lk_hit` and `lk_miss` are low.
- R5: An accepted insert writes the page number, context and attribute word. It goes to the lowest-numbered slot whose valid bit is clear, if there is one.
- R6: When no slot is empty, an insert replaces the least recently used unlocked slot. A lookup hit and an insert each make their slot the most recently used. After reset, slot 0 counts as most recent and the last slot as least recent.
- R7: A slot with the lock bit set is never replaced. If every slot is valid and locked, `ins_err` is high in the cycle of the insert and nothing changes.
- R8: A demap clears the valid bit of every valid, unlocked slot whose stored context equals `dm_ctx`. Locked slots and other contexts stay.
- R9: When demap and insert are requested in the same cycle, the insert is dropped without error. A lookup hit updates recency only in cycles with neither insert nor demap.
- R10: Slots with equal page numbers but different contexts coexist. When several slots match, the lowest-numbered one answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_ctx | input | 13 | Lookup context |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found none |
| lk_pa | output | 41 | Physical address, zero unless hit |
| lk_perm | output | 5 | Attribute bits 5..1 of the hit slot, zero unless hit |
| ins_valid | input | 1 | Insert request |
| ins_va | input | 64 | Virtual address of the new translation (bits 63..13 used) |
| ins_ctx | input | 13 | Context of the new translation |
| ins_data | input | 64 | Attribute word of the new translation |
| ins_err | output | 1 | Insert refused: every slot valid and locked |
| dm_valid | input | 1 | Demap request |
| dm_ctx | input | 13 | Context to demap |

## Verification
The hardest state to reach is one where the replacement choice depends on a history of hits and on locked slots scattered through a full buffer. The stimulus first fills all sixteen slots and then re-references some of them with lookups. It then inserts locked translations among unlocked ones, so that the oldest slot is often a locked one that must be skipped. The refusal case needs every slot to be locked, and locked slots cannot be removed. It is therefore built last, by filling the buffer with locked inserts after a demap has emptied it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 64;
  localparam int PG_BITS  = 13;
  localparam int VPN_W    = VA_W - PG_BITS;
  localparam int CTX_W    = 13;
  localparam int DATA_W   = 64;
  localparam int PPN_LO   = 13;
  localparam int PPN_W    = 28;
  localparam int PA_W     = PPN_W + PG_BITS;
  localparam int PERM_W   = 5;
  localparam int B_VALID  = 63;
  localparam int B_LOCK   = 6;
  localparam int B_GLOBAL = 0;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [CTX_W-1:0]  ctx;
    logic [DATA_W-1:0] data;
  } tlb_slot_t;
endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  tlb_slot_t        slots [N_ENT],
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [CTX_W-1:0] q_ctx,
  output logic             any_hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [N_ENT-1:0] match;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match[g] = slots[g].data[B_VALID] && (slots[g].vpn == q_vpn) &&
                      (slots[g].data[B_GLOBAL] || (slots[g].ctx == q_ctx));
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit = |match;
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   touch_en,
  input  logic [IDX_W-1:0]       touch_idx,
  input  logic [N_ENT-1:0]       valid_vec,
  input  logic [N_ENT-1:0]       lock_vec,
  output logic                   victim_ok,
  output logic [IDX_W-1:0]       victim_idx,
  output logic [N_ENT*IDX_W-1:0] rank_flat
);
  logic [IDX_W-1:0] rank_q [N_ENT];
  logic [IDX_W-1:0] rank_d [N_ENT];
  logic             free_ok, old_ok;
  logic [IDX_W-1:0] free_idx, old_idx, old_rank;

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      rank_d[i] = rank_q[i];
      if (IDX_W'(i) == touch_idx)            rank_d[i] = '0;
      else if (rank_q[i] < rank_q[touch_idx]) rank_d[i] = rank_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N_ENT; i++) rank_q[i] <= rank_d[i];
    end
  end

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    old_ok   = 1'b0;
    old_idx  = '0;
    old_rank = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (valid_vec[i] && !lock_vec[i] && (!old_ok || rank_q[i] > old_rank)) begin
        old_ok   = 1'b1;
        old_idx  = IDX_W'(i);
        old_rank = rank_q[i];
      end
    end
  end

  assign victim_ok  = free_ok | old_ok;
  assign victim_idx = free_ok ? free_idx : old_idx;

  for (genvar g = 0; g < N_ENT; g++) begin : g_flat
    assign rank_flat[g*IDX_W +: IDX_W] = rank_q[g];
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [CTX_W-1:0]  lk_ctx,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_pa,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              ins_valid,
  input  logic [VA_W-1:0]   ins_va,
  input  logic [CTX_W-1:0]  ins_ctx,
  input  logic [DATA_W-1:0] ins_data,
  output logic              ins_err,
  input  logic              dm_valid,
  input  logic [CTX_W-1:0]  dm_ctx
);
  logic                   rst_q_n;
  tlb_slot_t              slot_q [N_ENT];
  tlb_slot_t              slot_d [N_ENT];
  logic                   slot_en;
  logic [N_ENT-1:0]       valid_vec, lock_vec;
  logic                   any_hit;
  logic [IDX_W-1:0]       hit_idx;
  logic                   victim_ok;
  logic [IDX_W-1:0]       victim_idx;
  logic [N_ENT*IDX_W-1:0] rank_flat;
  logic                   ins_go, touch_en;
  logic [IDX_W-1:0]       touch_idx;
  tlb_slot_t              sel;

  tlb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  for (genvar g = 0; g < N_ENT; g++) begin : g_vec
    assign valid_vec[g] = slot_q[g].data[B_VALID];
    assign lock_vec[g]  = slot_q[g].data[B_LOCK];
  end

  tlb_match #(.N_ENT(N_ENT)) u_match (
    .slots(slot_q), .q_vpn(lk_va[VA_W-1:PG_BITS]), .q_ctx(lk_ctx),
    .any_hit(any_hit), .hit_idx(hit_idx)
  );

  tlb_lru #(.N_ENT(N_ENT)) u_lru (
    .clk(clk), .rst_n(rst_q_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .valid_vec(valid_vec), .lock_vec(lock_vec),
    .victim_ok(victim_ok), .victim_idx(victim_idx), .rank_flat(rank_flat)
  );

  assign ins_go    = ins_valid && !dm_valid && victim_ok;
  assign ins_err   = ins_valid && !dm_valid && !victim_ok;
  assign touch_en  = !dm_valid && (ins_go || (lk_valid && any_hit && !ins_valid));
  assign touch_idx = ins_go ? victim_idx : hit_idx;

  always_comb begin
    for (int i = 0; i < N_ENT; i++) slot_d[i] = slot_q[i];
    if (dm_valid) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (valid_vec[i] && !lock_vec[i] && (slot_q[i].ctx == dm_ctx))
          slot_d[i].data[B_VALID] = 1'b0;
      end
    end else if (ins_go) begin
      slot_d[victim_idx].vpn  = ins_va[VA_W-1:PG_BITS];
      slot_d[victim_idx].ctx  = ins_ctx;
      slot_d[victim_idx].data = ins_data;
    end
  end

  assign slot_en = dm_valid || ins_go;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      for (int i = 0; i < N_ENT; i++) slot_q[i] <= '0;
    end else if (slot_en) begin
      for (int i = 0; i < N_ENT; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign sel     = slot_q[hit_idx];
  assign lk_hit  = lk_valid && any_hit;
  assign lk_miss = lk_valid && !any_hit;
  assign lk_pa   = lk_hit ? {sel.data[PPN_LO +: PPN_W], lk_va[PG_BITS-1:0]} : '0;
  assign lk_perm = lk_hit ? sel.data[B_LOCK-1:B_GLOBAL+1] : '0;
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk
  import tlb_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic                   lk_hit,
  input logic                   lk_miss,
  input logic [PA_W-1:0]        lk_pa,
  input logic [PERM_W-1:0]      lk_perm,
  input logic                   ins_valid,
  input logic [DATA_W-1:0]      ins_data,
  input logic                   ins_err,
  input logic                   dm_valid,
  input logic [N_ENT-1:0]       valid_vec,
  input logic [N_ENT*IDX_W-1:0] rank_flat
);
  logic [N_ENT-1:0] rank_seen;

  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < N_ENT; i++) rank_seen[rank_flat[i*IDX_W +: IDX_W]] = 1'b1;
  end

  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({lk_hit, lk_miss}));
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit && !lk_miss);
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_pa == '0) && (lk_perm == '0));
  a_r7_err_needs_insert: assert property (@(posedge clk) disable iff (!rst_n)
    ins_err |-> ins_valid && (valid_vec == '1));
  a_r7_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    ins_err |=> $stable(valid_vec));
  a_r9_demap_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    dm_valid |-> !ins_err);
  a_r5_insert_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !dm_valid && ins_data[B_VALID]) |=>
      ($countones(valid_vec) >= $countones($past(valid_vec))));
  a_r6_rank_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    rank_seen == '1);
endmodule

bind ctx_tlb ctx_tlb_chk #(.N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_perm(lk_perm), .ins_valid(ins_valid),
  .ins_data(ins_data), .ins_err(ins_err), .dm_valid(dm_valid),
  .valid_vec(valid_vec), .rank_flat(rank_flat)
);

// File: tb/ctx_tlb_test.sv
module ctx_tlb_test;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [63:0] lk_va = '0;
  logic [12:0] lk_ctx = '0;
  logic        lk_hit, lk_miss, ins_err;
  logic [40:0] lk_pa;
  logic [4:0]  lk_perm;
  logic        ins_valid = 1'b0;
  logic [63:0] ins_va = '0;
  logic [12:0] ins_ctx = '0;
  logic [63:0] ins_data = '0;
  logic        dm_valid = 1'b0;
  logic [12:0] dm_ctx = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [50:0] m_vpn [N];
  logic [12:0] m_ctx [N];
  logic [63:0] m_data [N];
  int          order [$];

  always #4 clk = ~clk;

  ctx_tlb uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_ctx(lk_ctx),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_perm(lk_perm),
    .ins_valid(ins_valid), .ins_va(ins_va), .ins_ctx(ins_ctx), .ins_data(ins_data),
    .ins_err(ins_err), .dm_valid(dm_valid), .dm_ctx(dm_ctx)
  );

  function automatic logic [63:0] mkd(input logic [27:0] ppn, input logic lock,
                                      input logic glob, input logic [4:0] perm);
    return {1'b1, 22'b0, ppn, 6'b0, lock, perm, glob};
  endfunction

  function automatic logic [63:0] mkva(input logic [50:0] vpn, input logic [12:0] off);
    return {vpn, off};
  endfunction

  task automatic cmp(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic touch(input int e);
    for (int k = 0; k < order.size(); k++) begin
      if (order[k] == e) begin
        order.delete(k);
        break;
      end
    end
    order.push_front(e);
  endtask

  task automatic step(input logic lv, input logic [63:0] lva, input logic [12:0] lc,
                      input logic iv, input logic [63:0] iva, input logic [12:0] ic,
                      input logic [63:0] id, input logic dv, input logic [12:0] dc,
                      input string tag);
    int  hit_e, vic;
    logic e_hit, e_err;
    lk_valid = lv; lk_va = lva; lk_ctx = lc;
    ins_valid = iv; ins_va = iva; ins_ctx = ic; ins_data = id;
    dm_valid = dv; dm_ctx = dc;
    #1;
    hit_e = -1;
    for (int i = 0; i < N; i++) begin
      if (hit_e < 0 && m_data[i][63] && m_vpn[i] == lva[63:13] &&
          (m_data[i][0] || m_ctx[i] == lc)) hit_e = i;
    end
    vic = -1;
    for (int i = 0; i < N; i++) if (vic < 0 && !m_data[i][63]) vic = i;
    for (int k = order.size() - 1; k >= 0; k--) begin
      if (vic < 0 && m_data[order[k]][63] && !m_data[order[k]][6]) vic = order[k];
    end
    e_hit = lv && hit_e >= 0;
    e_err = iv && !dv && vic < 0;
    cmp(tag, "hit",  {63'b0, lk_hit},  {63'b0, e_hit});
    cmp(tag, "miss", {63'b0, lk_miss}, {63'b0, lv && !e_hit});
    cmp(tag, "pa",   {23'b0, lk_pa},
        e_hit ? {23'b0, m_data[hit_e][40:13], lva[12:0]} : 64'b0);
    cmp(tag, "perm", {59'b0, lk_perm}, e_hit ? {59'b0, m_data[hit_e][5:1]} : 64'b0);
    cmp(tag, "err",  {63'b0, ins_err}, {63'b0, e_err});
    @(posedge clk);
    if (dv) begin
      for (int i = 0; i < N; i++)
        if (m_data[i][63] && !m_data[i][6] && m_ctx[i] == dc) m_data[i][63] = 1'b0;
    end else if (iv && vic >= 0) begin
      m_vpn[vic] = iva[63:13]; m_ctx[vic] = ic; m_data[vic] = id;
      touch(vic);
    end else if (e_hit && !iv) begin
      touch(hit_e);
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [50:0] vpn, input logic [12:0] c, input string tag);
    step(1, mkva(vpn, 13'h0a5c), c, 0, '0, '0, '0, 0, '0, tag);
  endtask

  task automatic put(input logic [50:0] vpn, input logic [12:0] c,
                     input logic [63:0] d, input string tag);
    step(0, '0, '0, 1, mkva(vpn, 13'h1fff), c, d, 0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_ctx[i] = '0; m_data[i] = '0; order.push_back(i);
    end
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: empty after reset
    look(51'h100, 13'd5, "R1");
    step(0, '0, '0, 0, '0, '0, '0, 0, '0, "R1");

    // R5 R2: fill lowest empty slots, then hit
    put(51'h100, 13'd5, mkd(28'hABCDE01, 0, 0, 5'b10101), "R5");
    put(51'h200, 13'd5, mkd(28'h0000123, 0, 0, 5'b01010), "R5");
    put(51'h300, 13'd9, mkd(28'h7654321, 0, 1, 5'b11111), "R5");
    look(51'h100, 13'd5, "R2");
    look(51'h200, 13'd5, "R2");
    // R3: global matches other contexts
    look(51'h300, 13'd77, "R3");
    look(51'h300, 13'd9, "R3");
    // R4: wrong context, unknown page
    look(51'h100, 13'd6, "R4");
    look(51'h999, 13'd5, "R4");
    // R10: same page, another context
    put(51'h100, 13'd6, mkd(28'h1111111, 0, 0, 5'b00001), "R10");
    look(51'h100, 13'd6, "R10");
    look(51'h100, 13'd5, "R10");
    put(51'h100, 13'd6, mkd(28'h2222222, 0, 0, 5'b00010), "R10");
    look(51'h100, 13'd6, "R10");

    // R6: fill and evict by recency
    for (int k = 0; k < 14; k++)
      put(51'h1000 + k, 13'd3, mkd(28'h100 + k, 0, 0, 5'b00100), "R6");
    look(51'h100, 13'd5, "R6");
    look(51'h1002, 13'd3, "R6");
    step(1, mkva(51'h200, 0), 13'd5, 1, mkva(51'h2000, 0), 13'd3,
         mkd(28'h2000, 0, 0, 5'b0), 0, '0, "R9");
    for (int k = 0; k < 6; k++)
      put(51'h3000 + k, 13'd3, mkd(28'h300 + k, 0, 0, 5'b01000), "R6");
    for (int k = 0; k < 6; k++) look(51'h1000 + k, 13'd3, "R6");
    look(51'h100, 13'd5, "R6");

    // R7: locked slots survive replacement
    for (int k = 0; k < 3; k++)
      put(51'h4000 + k, 13'd3, mkd(28'h400 + k, 1, 0, 5'b10000), "R7");
    for (int k = 0; k < 20; k++)
      put(51'h5000 + k, 13'd4, mkd(28'h500 + k, 0, 0, 5'b00011), "R7");
    for (int k = 0; k < 3; k++) look(51'h4000 + k, 13'd3, "R7");

    // R8: demap context 4 and 3, locked stay
    step(0, '0, '0, 0, '0, '0, '0, 1, 13'd4, "R8");
    look(51'h5013, 13'd4, "R8");
    step(1, mkva(51'h4001, 13'h0123), 13'd3, 0, '0, '0, '0, 1, 13'd3, "R8");
    look(51'h4001, 13'd3, "R8");
    look(51'h4000, 13'd3, "R8");

    // R9: demap wins over insert
    step(0, '0, '0, 1, mkva(51'h6000, 0), 13'd8, mkd(28'h600, 0, 0, 5'b0),
         1, 13'd8, "R9");
    look(51'h6000, 13'd8, "R9");

    // R7: all slots locked, inserts refused
    for (int k = 0; k < 16; k++)
      put(51'h7000 + k, 13'd11, mkd(28'h700 + k, 1, 0, 5'b00110), "R7");
    look(51'h7000, 13'd11, "R7");
    look(51'h700c, 13'd11, "R7");
    look(51'h4002, 13'd3, "R7");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule